// File: doc/BRIEF.md
# Operand Bypass Selector

This block sits beside the execute stage of a five-stage in-order pipeline and chooses, for each of the two ALU operands, where the operand value comes from. There are three sources. The first is the register-file read carried in the decode/execute pipeline register. The second is the ALU result of the instruction one stage ahead, held in the execute/memory register. The third is the value about to be written back, held in the memory/writeback register.

The selector compares the two source register tags of the instruction in execute against the destination tag and write-enable of each of the two older stages. From that comparison it drives a 2-bit select and the selected 32-bit operand for each side. The writeback value is itself picked here: it is either the loaded memory word or the older ALU result, depending on a flag carried with the writeback stage.

The block is purely combinational. It has no clock and no reset, and every output follows its inputs within the same cycle. Load-use stalls, the pipeline registers and the ALU belong to the surrounding pipeline.

Top module: `fwd_unit`

## Requirements
- R1: `sel_a` is 2'b10 and `opnd_a` equals `exm_alu` whenever `exm_wen` is 1, `exm_rd` is nonzero and `exm_rd` equals `id_rs`.
- R2: `sel_b` is 2'b10 and `opnd_b` equals `exm_alu` whenever `exm_wen` is 1, `exm_rd` is nonzero and `exm_rd` equals `id_rt`.
- R3: When the R1/R2 condition for an operand is false, and `mwb_wen` is 1 with a nonzero `mwb_rd` equal to that operand's source tag, the select is 2'b01 and the operand is the writeback value.
- R4: When both older stages write the same nonzero register that an operand reads, the execute/memory result wins: the select is 2'b10, not 2'b01.
- R5: A destination tag of 0 never causes forwarding from either stage, even with its write-enable set.
- R6: A stage whose write-enable is 0 never causes forwarding, whatever its destination tag holds.
- R7: With no qualifying match, the select is 2'b00 and the operand equals the register-file value (`id_rs_val` for A, `id_rt_val` for B).
- R8: The writeback value is `mwb_load` when `mwb_from_mem` is 1 and `mwb_alu` when it is 0.
- R9: The two operands are decided independently, so both may forward from the same stage when `id_rs` equals `id_rt`, or from different stages in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| id_rs | input | 5 | First source register tag of the instruction in execute |
| id_rt | input | 5 | Second source register tag of the instruction in execute |
| id_rs_val | input | 32 | Register-file value read for the first source |
| id_rt_val | input | 32 | Register-file value read for the second source |
| exm_wen | input | 1 | Execute/memory instruction writes a register |
| exm_rd | input | 5 | Execute/memory destination tag |
| exm_alu | input | 32 | Execute/memory ALU result |
| mwb_wen | input | 1 | Memory/writeback instruction writes a register |
| mwb_rd | input | 5 | Memory/writeback destination tag |
| mwb_from_mem | input | 1 | Writeback value comes from memory load data |
| mwb_load | input | 32 | Load data in memory/writeback |
| mwb_alu | input | 32 | ALU result in memory/writeback |
| sel_a | output | 2 | Source select for operand A (00 register file, 01 writeback, 10 execute/memory) |
| sel_b | output | 2 | Source select for operand B, same encoding |
| opnd_a | output | 32 | Selected operand A |
| opnd_b | output | 32 | Selected operand B |

## Verification
A wrong tag comparison or a lost qualifier shows in the same cycle as a wrong select code on `sel_a` or `sel_b`. Because every data source carries a distinct value, the wrong choice also shows as an operand that matches a different input. A broken priority only shows when both older stages target the same register, so those chains are driven on purpose. Each output is sampled after its inputs settle, before the next stimulus is applied. A wrong writeback sub-select shows only on a writeback-forwarded operand, so both settings of the memory flag are exercised on that path.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [1:0] {
        SRC_RF  = 2'b00,
        SRC_WB  = 2'b01,
        SRC_EX  = 2'b10,
        SRC_RSV = 2'b11
    } src_sel_e;

    typedef struct packed {
        logic ex_hit;
        logic wb_hit;
    } hit_pair_t;

endpackage

// File: rtl/fwd_tag_match.sv
module fwd_tag_match #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src_tag,
    input  logic [REG_W-1:0] dst_tag,
    input  logic             dst_wen,
    output logic             hit
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic hit_d;

    always_comb begin
        hit_d = 1'b0;
        if (dst_wen && (dst_tag != ZERO_REG) && (dst_tag == src_tag)) begin
            hit_d = 1'b1;
        end
    end

    assign hit = hit_d;
endmodule

// File: rtl/fwd_prio.sv
module fwd_prio
    import fwd_pkg::*;
(
    input  hit_pair_t hits,
    output src_sel_e  sel
);
    src_sel_e sel_d;

    always_comb begin
        sel_d = SRC_RF;
        if (hits.ex_hit) begin
            sel_d = SRC_EX;
        end else if (hits.wb_hit) begin
            sel_d = SRC_WB;
        end
    end

    assign sel = sel_d;
endmodule

// File: rtl/fwd_opnd_mux.sv
module fwd_opnd_mux
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  src_sel_e          sel,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] ex_val,
    input  logic [DATA_W-1:0] wb_val,
    output logic [DATA_W-1:0] opnd
);
    logic [DATA_W-1:0] opnd_d;

    always_comb begin
        unique case (sel)
            SRC_EX:  opnd_d = ex_val;
            SRC_WB:  opnd_d = wb_val;
            default: opnd_d = rf_val;
        endcase
    end

    assign opnd = opnd_d;
endmodule

// File: rtl/fwd_wb_value.sv
module fwd_wb_value #(
    parameter int DATA_W = 32
) (
    input  logic              from_mem,
    input  logic [DATA_W-1:0] load_val,
    input  logic [DATA_W-1:0] alu_val,
    output logic [DATA_W-1:0] wb_val
);
    logic [DATA_W-1:0] wb_val_d;

    always_comb begin
        wb_val_d = from_mem ? load_val : alu_val;
    end

    assign wb_val = wb_val_d;
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int REG_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic [REG_W-1:0]  id_rs,
    input  logic [REG_W-1:0]  id_rt,
    input  logic [DATA_W-1:0] id_rs_val,
    input  logic [DATA_W-1:0] id_rt_val,
    input  logic              exm_wen,
    input  logic [REG_W-1:0]  exm_rd,
    input  logic [DATA_W-1:0] exm_alu,
    input  logic              mwb_wen,
    input  logic [REG_W-1:0]  mwb_rd,
    input  logic              mwb_from_mem,
    input  logic [DATA_W-1:0] mwb_load,
    input  logic [DATA_W-1:0] mwb_alu,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b
);
    localparam int NUM_OPND = 2;

    logic [REG_W-1:0]  src_tag  [NUM_OPND];
    logic [DATA_W-1:0] rf_val   [NUM_OPND];
    hit_pair_t         hits_d   [NUM_OPND];
    src_sel_e          sel_d    [NUM_OPND];
    logic [DATA_W-1:0] opnd_d   [NUM_OPND];
    logic [DATA_W-1:0] wb_val_d;

    assign src_tag[0] = id_rs;
    assign src_tag[1] = id_rt;
    assign rf_val[0]  = id_rs_val;
    assign rf_val[1]  = id_rt_val;

    fwd_wb_value #(.DATA_W(DATA_W)) wb_val_i (
        .from_mem (mwb_from_mem),
        .load_val (mwb_load),
        .alu_val  (mwb_alu),
        .wb_val   (wb_val_d)
    );

    for (genvar k = 0; k < NUM_OPND; k++) begin : g_opnd
        logic ex_hit_w;
        logic wb_hit_w;

        fwd_tag_match #(.REG_W(REG_W)) ex_match_i (
            .src_tag (src_tag[k]),
            .dst_tag (exm_rd),
            .dst_wen (exm_wen),
            .hit     (ex_hit_w)
        );

        fwd_tag_match #(.REG_W(REG_W)) wb_match_i (
            .src_tag (src_tag[k]),
            .dst_tag (mwb_rd),
            .dst_wen (mwb_wen),
            .hit     (wb_hit_w)
        );

        assign hits_d[k].ex_hit = ex_hit_w;
        assign hits_d[k].wb_hit = wb_hit_w;

        fwd_prio prio_i (
            .hits (hits_d[k]),
            .sel  (sel_d[k])
        );

        fwd_opnd_mux #(.DATA_W(DATA_W)) mux_i (
            .sel    (sel_d[k]),
            .rf_val (rf_val[k]),
            .ex_val (exm_alu),
            .wb_val (wb_val_d),
            .opnd   (opnd_d[k])
        );
    end

    assign sel_a  = sel_d[0];
    assign sel_b  = sel_d[1];
    assign opnd_a = opnd_d[0];
    assign opnd_b = opnd_d[1];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
    parameter int REG_W  = 5,
    parameter int DATA_W = 32
) (
    input logic [REG_W-1:0]  id_rs,
    input logic [REG_W-1:0]  id_rt,
    input logic [DATA_W-1:0] id_rs_val,
    input logic [DATA_W-1:0] id_rt_val,
    input logic              exm_wen,
    input logic [REG_W-1:0]  exm_rd,
    input logic [DATA_W-1:0] exm_alu,
    input logic              mwb_wen,
    input logic [REG_W-1:0]  mwb_rd,
    input logic              mwb_from_mem,
    input logic [DATA_W-1:0] mwb_load,
    input logic [DATA_W-1:0] mwb_alu,
    input logic [1:0]        sel_a,
    input logic [1:0]        sel_b,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    always_comb begin
        // R1
        if (exm_wen && exm_rd != ZERO_REG && exm_rd == id_rs) begin
            ex_fwd_a_chk: assert (sel_a == 2'b10 && opnd_a == exm_alu);
        end
        // R2
        if (exm_wen && exm_rd != ZERO_REG && exm_rd == id_rt) begin
            ex_fwd_b_chk: assert (sel_b == 2'b10 && opnd_b == exm_alu);
        end
        // R8
        if (sel_a == 2'b01) begin
            wb_val_a_chk: assert (opnd_a == (mwb_from_mem ? mwb_load : mwb_alu));
        end
        // R5
        if (exm_rd == ZERO_REG && mwb_rd == ZERO_REG) begin
            zero_reg_chk: assert (sel_a == 2'b00 && sel_b == 2'b00);
        end
        // R6
        if (!exm_wen && !mwb_wen) begin
            no_wen_chk: assert (sel_a == 2'b00 && sel_b == 2'b00);
        end
        // R7
        if (sel_b == 2'b00) begin
            rf_pass_b_chk: assert (opnd_b == id_rt_val);
        end
        // R3
        if (sel_a == 2'b01) begin
            wb_match_a_chk: assert (mwb_wen && mwb_rd == id_rs && mwb_rd != ZERO_REG);
        end
    end
endmodule

bind fwd_unit fwd_unit_chk #(.REG_W(REG_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/fwd_unit_tb_top.sv
module fwd_unit_tb_top;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [4:0]  id_rs, id_rt, exm_rd, mwb_rd;
    logic [31:0] id_rs_val, id_rt_val, exm_alu, mwb_load, mwb_alu;
    logic        exm_wen, mwb_wen, mwb_from_mem;
    logic [1:0]  sel_a, sel_b;
    logic [31:0] opnd_a, opnd_b;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [31:0] V_RS = 32'hA000_0001;
    localparam logic [31:0] V_RT = 32'hB000_0002;
    localparam logic [31:0] V_EX = 32'hC000_0003;
    localparam logic [31:0] V_LD = 32'hD000_0004;
    localparam logic [31:0] V_WA = 32'hE000_0005;

    fwd_unit dut_i (
        .id_rs(id_rs), .id_rt(id_rt), .id_rs_val(id_rs_val), .id_rt_val(id_rt_val),
        .exm_wen(exm_wen), .exm_rd(exm_rd), .exm_alu(exm_alu),
        .mwb_wen(mwb_wen), .mwb_rd(mwb_rd), .mwb_from_mem(mwb_from_mem),
        .mwb_load(mwb_load), .mwb_alu(mwb_alu),
        .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic drive(input logic [4:0] rs, input logic [4:0] rt,
                         input logic ew, input logic [4:0] erd,
                         input logic ww, input logic [4:0] wrd, input logic fm);
        @(negedge clk);
        id_rs = rs; id_rt = rt;
        exm_wen = ew; exm_rd = erd;
        mwb_wen = ww; mwb_rd = wrd; mwb_from_mem = fm;
        #2;
    endtask

    task automatic expect_ab(input string req, input logic [1:0] sa, input logic [31:0] va,
                             input logic [1:0] sb, input logic [31:0] vb);
        check({req, " sel_a"}, {30'd0, sel_a}, {30'd0, sa});
        check({req, " opnd_a"}, opnd_a, va);
        check({req, " sel_b"}, {30'd0, sel_b}, {30'd0, sb});
        check({req, " opnd_b"}, opnd_b, vb);
    endtask

    task automatic t_idle();
        // R6 / R7: tags collide but nobody writes
        drive(5'd3, 5'd4, 1'b0, 5'd3, 1'b0, 5'd4, 1'b0);
        expect_ab("R6", 2'b00, V_RS, 2'b00, V_RT);
        drive(5'd3, 5'd4, 1'b1, 5'd9, 1'b1, 5'd10, 1'b0);
        expect_ab("R7", 2'b00, V_RS, 2'b00, V_RT);
    endtask

    task automatic t_ex_a();
        // R1
        drive(5'd7, 5'd8, 1'b1, 5'd7, 1'b0, 5'd0, 1'b0);
        expect_ab("R1", 2'b10, V_EX, 2'b00, V_RT);
    endtask

    task automatic t_ex_b();
        // R2
        drive(5'd7, 5'd8, 1'b1, 5'd8, 1'b0, 5'd0, 1'b0);
        expect_ab("R2", 2'b00, V_RS, 2'b10, V_EX);
    endtask

    task automatic t_wb();
        // R3 with ALU writeback, R8 both flavours
        drive(5'd11, 5'd12, 1'b0, 5'd11, 1'b1, 5'd11, 1'b0);
        expect_ab("R3", 2'b01, V_WA, 2'b00, V_RT);
        drive(5'd11, 5'd12, 1'b1, 5'd5, 1'b1, 5'd12, 1'b1);
        expect_ab("R8", 2'b00, V_RS, 2'b01, V_LD);
    endtask

    task automatic t_prio();
        // R4: both stages write the same register
        drive(5'd1, 5'd1, 1'b1, 5'd1, 1'b1, 5'd1, 1'b1);
        expect_ab("R4", 2'b10, V_EX, 2'b10, V_EX);
    endtask

    task automatic t_zero();
        // R5: destination zero with write-enable set
        drive(5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0, 1'b1);
        expect_ab("R5", 2'b00, V_RS, 2'b00, V_RT);
        // R5: ex writes zero, wb still forwards for matching tag
        drive(5'd0, 5'd6, 1'b1, 5'd0, 1'b1, 5'd6, 1'b0);
        expect_ab("R5", 2'b00, V_RS, 2'b01, V_WA);
    endtask

    task automatic t_mixed();
        // R9: different stages per operand in one cycle
        drive(5'd20, 5'd21, 1'b1, 5'd21, 1'b1, 5'd20, 1'b1);
        expect_ab("R9", 2'b01, V_LD, 2'b10, V_EX);
        // R9: shared tag, both from writeback
        drive(5'd30, 5'd30, 1'b1, 5'd2, 1'b1, 5'd30, 1'b0);
        expect_ab("R9", 2'b01, V_WA, 2'b01, V_WA);
    endtask

    initial begin
        id_rs_val = V_RS; id_rt_val = V_RT; exm_alu = V_EX;
        mwb_load = V_LD; mwb_alu = V_WA;
        id_rs = '0; id_rt = '0; exm_rd = '0; mwb_rd = '0;
        exm_wen = 1'b0; mwb_wen = 1'b0; mwb_from_mem = 1'b0;
        #2;
        expect_ab("R7", 2'b00, V_RS, 2'b00, V_RT);
        t_idle();
        t_ex_a();
        t_ex_b();
        t_wb();
        t_prio();
        t_zero();
        t_mixed();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule